// File: doc/BRIEF.md
# Eight-Register ALU Execute Stage

This block is the execute stage of a small 16-bit coprocessor. It holds eight general registers, R0 to R7. Each operation arrives already decoded: an operation code, a destination index, two source indices, a load value and a valid strobe. The stage reads its register file, computes a result and a new set of condition flags (N, Z, V, C), and on the next clock edge writes the result back. The write is skipped when the destination is R0, so an operation aimed at R0 works as a compare or a test that only changes the flags.

Arithmetic and logic operations take three operands: the destination receives the first source combined with the second. Logical shifts take two: the destination register is shifted by the amount held in the second source register, and the result replaces it. A load operation places an externally supplied value into the destination, which is how data reaches the register file. The most recent result and the flags are registered outputs, so the stage that follows can use them.

Top module: `alu8_exec`

## Requirements
- R1: After reset, every register reads as 0, `flags` is 4'b0000, `res_data` is 0 and `res_we` is 0.
- R2: R0 always reads as 0. An operation with `dst_idx` = 0 updates `flags` and `res_data` but writes no register, and `res_we` stays 0.
- R3: ADD (code 0) yields src1+src2, and ADC (code 1) yields src1+src2+C. C is the carry out of bit 15 and V is the signed overflow.
- R4: SUB (code 2) yields src1-src2, and SBC (code 3) yields src1-src2-C. C is set on unsigned borrow and V on signed overflow.
- R5: AND, OR, XOR and XNOR (codes 4 to 7) combine src1 with src2. They clear V and leave C unchanged.
- R6: LSL (code 8) shifts register dst left by the value of register src2 and writes the result back to dst. C is the last bit shifted out (0 for a zero shift), V is 0, and src1 is ignored.
- R7: LSR (code 9) shifts register dst right, filling with zeros, by the value of register src2. C is the last bit shifted out (0 for a zero shift) and V is 0.
- R8: A shift amount of 16 gives result 0, with C equal to bit 0 (LSL) or bit 15 (LSR) of the operand. An amount of 17 or more gives result 0 with C = 0.
- R9: Results, flags and `res_we` are visible after the rising edge that samples `op_valid`=1. An operation issued in the very next cycle reads the value just written.
- R10: When `op_valid` is 0, or the code is undefined (11 to 15), no register, flag or `res_data` changes, and `res_we` is 0 after the edge.
- R11: LOAD (code 10) writes `ld_data` to dst. N and Z come from the value, V is cleared and C is unchanged.
- R12: In every defined operation, N is bit 15 of the result and Z is set when the result is 0. `flags` is packed as {N,Z,V,C} in bits 3..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Qualifies the operation on the other inputs |
| op_code | input | 4 | Decoded operation code |
| dst_idx | input | 3 | Destination register; also the shifted operand for shifts |
| src1_idx | input | 3 | First source register |
| src2_idx | input | 3 | Second source register; holds the shift amount for shifts |
| ld_data | input | 16 | Value written by LOAD |
| res_data | output | 16 | Result of the last executed operation |
| res_we | output | 1 | High for one cycle after a register was written |
| flags | output | 4 | Condition flags {N,Z,V,C} |

## Verification
Every result is due exactly one rising edge after the stimulus. The bench drives each operation on a falling edge, waits for the next rising edge and samples 2 ns later. It then drops `op_valid` before the following edge, so the operation runs only once. Register contents are read back one cycle later with an OR into R0, which shows any write-back error through `res_data` without looking inside the design. Back-to-back operations check that a value written at one edge is already the operand in the following cycle.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBC  = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_XNOR = 4'd7,
    OP_LSL  = 4'd8,
    OP_LSR  = 4'd9,
    OP_LOAD = 4'd10
  } op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

  function automatic logic is_logic_op(input op_e op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) || (op == OP_XNOR);
  endfunction

  function automatic logic is_shift_op(input op_e op);
    return (op == OP_LSL) || (op == OP_LSR);
  endfunction

endpackage

// File: rtl/alu8_regfile.sv
module alu8_regfile #(
  parameter int DW   = 16,
  parameter int NREG = 8,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] rd_idx_d,
  input  logic [IW-1:0] rd_idx_1,
  input  logic [IW-1:0] rd_idx_2,
  output logic [DW-1:0] rd_d,
  output logic [DW-1:0] rd_1,
  output logic [DW-1:0] rd_2,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data
);

  logic [DW-1:0] bank [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == 0) begin : g_zero
      // R0 has no storage and reads as zero
      assign bank[g] = '0;
    end else begin : g_store
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                q <= '0;
        else if (wr_en && (wr_idx == IW'(g)))      q <= wr_data;
      end
      assign bank[g] = q;
    end
  end

  assign rd_d = bank[rd_idx_d];
  assign rd_1 = bank[rd_idx_1];
  assign rd_2 = bank[rd_idx_2];

  // R2: the write gating upstream never targets R0
  p_r0_never_written_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx != '0));

endmodule

// File: rtl/alu8_alu.sv
module alu8_alu
  import alu8_pkg::*;
#(
  parameter int DW = 16
) (
  input  op_e           op,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic [DW-1:0] ld_val,
  input  flags_t        cur_flg,
  output logic [DW-1:0] res,
  output flags_t        nxt_flg,
  output logic          defined,
  output logic          carry_w,
  output logic          borrow_w,
  output logic          shout_w
);

  localparam logic [DW-1:0] SHLIM = DW;

  // {carry, sum}
  function automatic logic [DW:0] add_f(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                        input logic ci);
    return {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, ci};
  endfunction

  // {borrow, difference}: the top bit wraps to 1 when a borrow occurs
  function automatic logic [DW:0] sub_f(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                        input logic bi);
    return {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, bi};
  endfunction

  function automatic logic add_ovf(input logic sa, input logic sb, input logic sr);
    return (sa == sb) && (sr != sa);
  endfunction

  function automatic logic sub_ovf(input logic sa, input logic sb, input logic sr);
    return (sa != sb) && (sr != sa);
  endfunction

  // {last bit out, result}; a zero shift yields a zero carry
  function automatic logic [DW:0] shl_f(input logic [DW-1:0] a, input logic [DW-1:0] n);
    logic [DW:0] t;
    t = {1'b0, a};
    if (n > SHLIM) return '0;
    return t << n;
  endfunction

  // {result, last bit out}
  function automatic logic [DW:0] shr_f(input logic [DW-1:0] a, input logic [DW-1:0] n);
    logic [DW:0] t;
    t = {a, 1'b0};
    if (n > SHLIM) return '0;
    return t >> n;
  endfunction

  logic [DW:0] sum_w, diff_w, shl_w, shr_w;
  logic        cin_arith;

  assign cin_arith = ((op == OP_ADC) || (op == OP_SBC)) ? cur_flg.c : 1'b0;
  assign sum_w     = add_f(opa, opb, cin_arith);
  assign diff_w    = sub_f(opa, opb, cin_arith);
  assign shl_w     = shl_f(opa, opb);
  assign shr_w     = shr_f(opa, opb);
  assign carry_w   = sum_w[DW];
  assign borrow_w  = diff_w[DW];
  assign shout_w   = (op == OP_LSL) ? shl_w[DW] : shr_w[0];

  always_comb begin
    res       = '0;
    nxt_flg   = cur_flg;
    nxt_flg.v = 1'b0;
    defined   = 1'b1;
    case (op)
      OP_ADD, OP_ADC: begin
        res       = sum_w[DW-1:0];
        nxt_flg.c = carry_w;
        nxt_flg.v = add_ovf(opa[DW-1], opb[DW-1], res[DW-1]);
      end
      OP_SUB, OP_SBC: begin
        res       = diff_w[DW-1:0];
        nxt_flg.c = borrow_w;
        nxt_flg.v = sub_ovf(opa[DW-1], opb[DW-1], res[DW-1]);
      end
      OP_AND:  res = opa & opb;
      OP_OR:   res = opa | opb;
      OP_XOR:  res = opa ^ opb;
      OP_XNOR: res = ~(opa ^ opb);
      OP_LSL: begin
        res       = shl_w[DW-1:0];
        nxt_flg.c = shout_w;
      end
      OP_LSR: begin
        res       = shr_w[DW:1];
        nxt_flg.c = shout_w;
      end
      OP_LOAD: res = ld_val;
      default: begin
        defined = 1'b0;
        nxt_flg = cur_flg;
      end
    endcase
    if (defined) begin
      nxt_flg.n = res[DW-1];
      nxt_flg.z = (res == '0);
    end
  end

endmodule

// File: rtl/alu8_wbreg.sv
module alu8_wbreg
  import alu8_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic          wen,
  input  logic [DW-1:0] nxt_res,
  input  flags_t        nxt_flg,
  output logic [DW-1:0] res_q,
  output flags_t        flg_q,
  output logic          we_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      flg_q <= '0;
      we_q  <= 1'b0;
    end else begin
      we_q <= fire && wen;
      if (fire) begin
        res_q <= nxt_res;
        flg_q <= nxt_flg;
      end
    end
  end

  // R10: no executed operation, no change
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> ($stable(flg_q) && $stable(res_q) && !we_q));

endmodule

// File: rtl/alu8_exec.sv
module alu8_exec
  import alu8_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NREG = 8,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [3:0]    op_code,
  input  logic [IW-1:0] dst_idx,
  input  logic [IW-1:0] src1_idx,
  input  logic [IW-1:0] src2_idx,
  input  logic [DW-1:0] ld_data,
  output logic [DW-1:0] res_data,
  output logic          res_we,
  output logic [3:0]    flags
);

  localparam logic [DW-1:0] SHLIM = DW;

  op_e           op_w;
  logic [DW-1:0] rd_d, rd_1, rd_2;
  logic [DW-1:0] opa, alu_res;
  flags_t        cur_flg, alu_flg;
  logic          defined, fire, wen;
  logic          carry_w, borrow_w, shout_w;

  assign op_w = op_e'(op_code);

  alu8_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx_d (dst_idx),
    .rd_idx_1 (src1_idx),
    .rd_idx_2 (src2_idx),
    .rd_d     (rd_d),
    .rd_1     (rd_1),
    .rd_2     (rd_2),
    .wr_en    (fire && wen),
    .wr_idx   (dst_idx),
    .wr_data  (alu_res)
  );

  // dyadic shifts operate on the destination register itself
  assign opa = is_shift_op(op_w) ? rd_d : rd_1;

  alu8_alu #(.DW(DW)) u_alu (
    .op       (op_w),
    .opa      (opa),
    .opb      (rd_2),
    .ld_val   (ld_data),
    .cur_flg  (cur_flg),
    .res      (alu_res),
    .nxt_flg  (alu_flg),
    .defined  (defined),
    .carry_w  (carry_w),
    .borrow_w (borrow_w),
    .shout_w  (shout_w)
  );

  assign fire = op_valid && defined;
  assign wen  = (dst_idx != '0);

  alu8_wbreg #(.DW(DW)) u_wb (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (fire),
    .wen     (wen),
    .nxt_res (alu_res),
    .nxt_flg (alu_flg),
    .res_q   (res_data),
    .flg_q   (cur_flg),
    .we_q    (res_we)
  );

  assign flags = cur_flg;

  // R5: logic operations clear V and keep C
  p_logic_v_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && is_logic_op(op_w)) |=> (!flags[1] && (flags[0] == $past(flags[0]))));

  // R8: shifting by more than the width gives zero and no carry
  p_shift_far_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && is_shift_op(op_w) && (rd_2 > SHLIM)) |=> ((res_data == '0) && !flags[0]));

  // R12: Z follows the registered result after every write
  p_z_tracks_result_r12: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> (flags[2] == (res_data == '0)));

  // R4: a subtract with a larger unsigned subtrahend reports a borrow
  p_sub_borrow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (op_w == OP_SUB) && (rd_2 > rd_1)) |=> flags[0]);

endmodule

// File: tb/sim_alu8_exec.sv
module sim_alu8_exec;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  op_code = '0;
  logic [2:0]  dst_idx = '0, src1_idx = '0, src2_idx = '0;
  logic [15:0] ld_data = '0;
  logic [15:0] res_data;
  logic        res_we;
  logic [3:0]  flags;

  int n_chk = 0, n_bad = 0;
  logic [15:0] m_reg [8];
  logic [3:0]  m_flg;
  logic [15:0] m_res;

  always #4 clk = ~clk;

  alu8_exec u0 (.clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
                .dst_idx(dst_idx), .src1_idx(src1_idx), .src2_idx(src2_idx),
                .ld_data(ld_data), .res_data(res_data), .res_we(res_we), .flags(flags));

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // returns {defined, N, Z, V, C, result}
  function automatic logic [20:0] model(input logic [3:0] op, input logic [15:0] a,
                                        input logic [15:0] b, input logic [15:0] ld,
                                        input logic [3:0] fl);
    logic [15:0] r;
    logic c, v;
    int ia, ib, ci, sa, sb, t;
    ia = a; ib = b; sa = $signed(a); sb = $signed(b);
    c = fl[0]; v = 1'b0; r = '0;
    ci = (op == 4'd1 || op == 4'd3) ? int'(fl[0]) : 0;
    case (op)
      4'd0, 4'd1: begin
        t = ia + ib + ci; r = t[15:0]; c = (t > 65535);
        t = sa + sb + ci; v = (t > 32767) || (t < -32768);
      end
      4'd2, 4'd3: begin
        t = ia - ib - ci; r = t[15:0]; c = (t < 0);
        t = sa - sb - ci; v = (t > 32767) || (t < -32768);
      end
      4'd4: r = a & b;
      4'd5: r = a | b;
      4'd6: r = a ^ b;
      4'd7: r = ~(a ^ b);
      4'd8: begin
        r = a; c = 1'b0;
        for (int i = 0; i < ib && i < 17; i++) begin c = r[15]; r = r << 1; end
      end
      4'd9: begin
        r = a; c = 1'b0;
        for (int i = 0; i < ib && i < 17; i++) begin c = r[0]; r = r >> 1; end
      end
      4'd10: r = ld;
      default: return {1'b0, fl, m_res};
    endcase
    return {1'b1, r[15], (r == 16'h0), v, c, r};
  endfunction

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd0, 4'd1: return "R3";
      4'd2, 4'd3: return "R4";
      4'd4, 4'd5, 4'd6, 4'd7: return "R5";
      4'd8: return "R6";
      4'd9: return "R7";
      4'd10: return "R11";
      default: return "R10";
    endcase
  endfunction

  task automatic run_op(input logic [3:0] op, input logic [2:0] d, input logic [2:0] s1,
                        input logic [2:0] s2, input logic [15:0] ld, input string req);
    logic [20:0] e;
    logic [15:0] a;
    @(negedge clk);
    op_valid = 1'b1; op_code = op; dst_idx = d; src1_idx = s1; src2_idx = s2; ld_data = ld;
    a = (op == 4'd8 || op == 4'd9) ? m_reg[d] : m_reg[s1];
    e = model(op, a, m_reg[s2], ld, m_flg);
    @(posedge clk); #2;
    op_valid = 1'b0;
    chk(res_data == e[15:0], req, "result", res_data, e[15:0]);
    chk(flags == e[19:16], req, "flags NZVC", {12'h0, flags}, {12'h0, e[19:16]});
    chk(res_we == (e[20] && d != 3'd0), req, "res_we", {15'h0, res_we},
        {15'h0, (e[20] && d != 3'd0)});
    if (e[20]) begin
      m_res = e[15:0]; m_flg = e[19:16];
      if (d != 3'd0) m_reg[d] = e[15:0];
    end
  endtask

  // reads register k through an OR into R0
  task automatic peek(input logic [2:0] k, input string req);
    run_op(4'd5, 3'd0, k, 3'd0, 16'h0, req);
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    op_valid = 1'b0; op_code = 4'd0; dst_idx = 3'd1; src1_idx = 3'd2; src2_idx = 3'd3;
    @(posedge clk); #2;
    chk(res_data == m_res, "R10", "idle result", res_data, m_res);
    chk(flags == m_flg, "R10", "idle flags", {12'h0, flags}, {12'h0, m_flg});
    chk(res_we == 1'b0, "R10", "idle res_we", {15'h0, res_we}, 16'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [3:0] op;
    void'($urandom(32'h5EED));
    for (int i = 0; i < 8; i++) m_reg[i] = '0;
    m_flg = '0; m_res = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1: reset state
    chk(flags == 4'h0, "R1", "reset flags", {12'h0, flags}, 16'h0);
    chk(res_data == 16'h0, "R1", "reset result", res_data, 16'h0);
    chk(res_we == 1'b0, "R1", "reset res_we", {15'h0, res_we}, 16'h0);
    for (int k = 1; k < 8; k++) peek(3'(k), "R1");

    // directed corner cases
    run_op(4'd10, 3'd1, 3'd0, 3'd0, 16'hFFFF, "R11");
    run_op(4'd10, 3'd2, 3'd0, 3'd0, 16'h0001, "R11");
    run_op(4'd0, 3'd3, 3'd1, 3'd2, 16'h0, "R3");    // 0xFFFF+1: zero, carry
    run_op(4'd10, 3'd4, 3'd0, 3'd0, 16'h7FFF, "R11");
    run_op(4'd0, 3'd5, 3'd4, 3'd2, 16'h0, "R3");    // signed overflow
    run_op(4'd0, 3'd0, 3'd1, 3'd2, 16'h0, "R2");    // compare into R0 sets C
    peek(3'd0, "R2");
    run_op(4'd0, 3'd0, 3'd1, 3'd2, 16'h0, "R2");
    run_op(4'd1, 3'd6, 3'd2, 3'd2, 16'h0, "R3");    // ADC with C=1 gives 3
    run_op(4'd2, 3'd7, 3'd2, 3'd1, 16'h0, "R4");    // 1-0xFFFF borrows
    run_op(4'd3, 3'd7, 3'd7, 3'd2, 16'h0, "R4");
    run_op(4'd2, 3'd0, 3'd2, 3'd2, 16'h0, "R4");    // equal compare: Z set
    run_op(4'd6, 3'd3, 3'd1, 3'd4, 16'h0, "R5");
    run_op(4'd10, 3'd5, 3'd0, 3'd0, 16'd16, "R11");
    run_op(4'd10, 3'd6, 3'd0, 3'd0, 16'h8001, "R11");
    run_op(4'd8, 3'd6, 3'd0, 3'd5, 16'h0, "R8");    // LSL by 16
    run_op(4'd10, 3'd6, 3'd0, 3'd0, 16'h8001, "R11");
    run_op(4'd9, 3'd6, 3'd0, 3'd5, 16'h0, "R8");    // LSR by 16
    run_op(4'd10, 3'd5, 3'd0, 3'd0, 16'd17, "R11");
    run_op(4'd10, 3'd6, 3'd0, 3'd0, 16'hFFFF, "R11");
    run_op(4'd8, 3'd6, 3'd0, 3'd5, 16'h0, "R8");    // LSL by 17
    run_op(4'd10, 3'd6, 3'd0, 3'd0, 16'hA5C3, "R11");
    run_op(4'd8, 3'd6, 3'd1, 3'd0, 16'h0, "R6");    // zero shift
    run_op(4'd10, 3'd4, 3'd0, 3'd0, 16'd3, "R11");
    run_op(4'd9, 3'd6, 3'd0, 3'd4, 16'h0, "R7");
    run_op(4'd10, 3'd1, 3'd0, 3'd0, 16'd5, "R9");   // back to back
    run_op(4'd0, 3'd2, 3'd1, 3'd1, 16'h0, "R9");
    run_op(4'd13, 3'd2, 3'd1, 3'd1, 16'h0, "R10");  // undefined code
    peek(3'd2, "R10");
    idle_cycle();

    // constrained random mix
    for (int it = 0; it < 1500; it++) begin
      if ($urandom_range(0, 3) == 0) begin
        run_op(4'd10, 3'($urandom_range(0, 7)), 3'd0, 3'd0,
               ($urandom_range(0, 1) == 1) ? 16'($urandom_range(0, 19)) : 16'($urandom),
               "R11");
      end else begin
        op = 4'($urandom_range(0, 11));
        if (op == 4'd11) op = 4'($urandom_range(11, 15));
        run_op(op, 3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)),
               3'($urandom_range(0, 7)), 16'($urandom), req_of(op));
      end
      if ($urandom_range(0, 15) == 0) idle_cycle();
      if ($urandom_range(0, 7) == 0) peek(3'($urandom_range(0, 7)), "R12");
    end
    for (int k = 0; k < 8; k++) peek(3'(k), "R2");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule